// File: doc/BRIEF.md
# Pixel Component Unpacker

The block takes one pixel word per beat from an upstream pixel FIFO and turns it into three 8-bit colour components: red, green and blue. The pixel word holds up to four framebuffer bytes in little-endian order, so the first byte of the pixel sits in bits 7:0. A format word sets how many of those bytes belong to the pixel, and the unused upper bytes read as zero.

Each colour has its own select word. It names the lowest bit of the colour field, how many bits the field has, and a fallback value. The field is widened or narrowed to eight bits. The fallback value takes its place when the channel is switched off (field length zero), when the beat lies outside the visible area, or when the FIFO reports an underrun. The result is registered once and leaves with a valid strobe.

Top module: `pixel_unpacker`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock. The components change only on the clock edge that samples `in_valid` high. Reset clears `out_valid` and all three components to zero.
- R2: Each select word is decoded as follows: fallback value in bits 23:16, field length in bits 11:8, lowest field bit in bits 4:0. The field covers the pixel-word bits from the lowest field bit up to that bit plus the length minus one. Byte k of the pixel occupies pixel-word bits 8k+7:8k. The three channels are decoded independently of each other.
- R3: When the field length of a channel is zero, that channel outputs its fallback value.
- R4: When `in_visible` is low, all three channels output their fallback values.
- R5: When `in_underrun` is high, all three channels output their fallback values, whatever the pixel word holds.
- R6: Format word bits 4:3 hold the bytes per pixel minus one, so 0 means one byte and 3 means four bytes. Pixel-word bytes above that count read as zero. Field bits above bit 31 also read as zero.
- R7: A field shorter than 8 bits is placed at the top of the component. Its bits are then repeated from its most significant bit downward until the low bits are filled: a 5-bit field of 10000 gives 0x84, and a 2-bit field of 01 gives 0x55.
- R8: A field of exactly 8 bits passes through unchanged. A longer field keeps only its 8 most significant bits.
- R9: While `in_valid` is low, the components keep the values of the last accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixfmt_cfg | input | 32 | Format word; bits 4:3 hold bytes per pixel minus one |
| sel_red | input | 32 | Red select word |
| sel_green | input | 32 | Green select word |
| sel_blue | input | 32 | Blue select word |
| in_valid | input | 1 | A pixel beat is present |
| in_word | input | 32 | Pixel word, little-endian bytes |
| in_visible | input | 1 | The beat lies inside the visible area |
| in_underrun | input | 1 | The FIFO had no data for this beat |
| out_valid | output | 1 | The registered components are new |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |

## Verification
The properties assume that the format and select words stay fixed for the whole beat they apply to, and that `in_visible` and `in_underrun` are defined whenever `in_valid` is high. The bench changes all inputs only on falling edges and holds them through the sampling edge. It reprograms the configuration only between beats, never while a beat is being captured. It also keeps the lowest field bit plus the field length within the pixel word, except in the single vector that deliberately reads past bit 31.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    localparam int SEL_DEF_LSB = 16;
    localparam int SEL_CNT_LSB = 8;
    localparam int SEL_CNT_W   = 4;
    localparam int SEL_POS_LSB = 0;
    localparam int SEL_POS_W   = 5;
    localparam int FMT_LSB     = 3;
    localparam int NUM_CHAN    = 3;

    typedef struct packed {
        logic                 valid;
        logic [NUM_CHAN-1:0][7:0] comp;
    } pxu_state_t;
endpackage

// File: rtl/pxu_byte_gate.sv
module pxu_byte_gate #(
    parameter int WORD_BYTES = 4,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int BPP_W     = $clog2(WORD_BYTES)
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [BPP_W-1:0]  bytes_m1_i,
    output logic [WORD_W-1:0] word_o
);
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
        localparam logic [BPP_W-1:0] KIDX = BPP_W'(k);
        assign word_o[8*k +: 8] = (KIDX <= bytes_m1_i) ? word_i[8*k +: 8] : 8'h00;
    end
endmodule

// File: rtl/pxu_channel.sv
module pxu_channel
    import pxu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SEL_W  = 32,
    parameter int COMP_W = 8
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              use_def_i,
    output logic [COMP_W-1:0] comp_o
);
    logic [SEL_CNT_W-1:0] len;
    logic [SEL_POS_W-1:0] pos;
    logic [COMP_W-1:0]    fallback;
    logic [WORD_W-1:0]    shifted;
    logic [COMP_W-1:0]    packed_bits;
    logic [SEL_CNT_W-1:0] idx;

    assign len      = sel_i[SEL_CNT_LSB +: SEL_CNT_W];
    assign pos      = sel_i[SEL_POS_LSB +: SEL_POS_W];
    assign fallback = sel_i[SEL_DEF_LSB +: COMP_W];
    assign shifted  = word_i >> pos;

    // Walk the field from its top bit downward, wrapping to the top again
    // when it runs out: this both truncates long fields and repeats short ones.
    always_comb begin
        idx = len - 1'b1;
        packed_bits = '0;
        for (int b = 0; b < COMP_W; b++) begin
            packed_bits[COMP_W-1-b] = shifted[idx];
            idx = (idx == '0) ? (len - 1'b1) : (idx - 1'b1);
        end
    end

    assign comp_o = (use_def_i || (len == '0)) ? fallback : packed_bits;
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
    import pxu_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int SEL_W      = 32,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int BPP_W     = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  pixfmt_cfg,
    input  logic [SEL_W-1:0]  sel_red,
    input  logic [SEL_W-1:0]  sel_green,
    input  logic [SEL_W-1:0]  sel_blue,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_visible,
    input  logic              in_underrun,
    output logic              out_valid,
    output logic [7:0]        out_red,
    output logic [7:0]        out_green,
    output logic [7:0]        out_blue
);
    pxu_state_t st_d, st_q;

    logic [WORD_W-1:0]              gated_word;
    logic [NUM_CHAN-1:0][SEL_W-1:0] sel_all;
    logic [NUM_CHAN-1:0][7:0]       comp_all;
    logic                           force_def;

    assign sel_all   = {sel_blue, sel_green, sel_red};
    assign force_def = in_underrun || !in_visible;

    pxu_byte_gate #(.WORD_BYTES(WORD_BYTES)) u_gate (
        .word_i     (in_word),
        .bytes_m1_i (pixfmt_cfg[FMT_LSB +: BPP_W]),
        .word_o     (gated_word)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        pxu_channel #(.WORD_W(WORD_W), .SEL_W(SEL_W), .COMP_W(8)) u_chan (
            .word_i    (gated_word),
            .sel_i     (sel_all[c]),
            .use_def_i (force_def),
            .comp_o    (comp_all[c])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.comp = comp_all;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_red   = st_q.comp[0];
    assign out_green = st_q.comp[1];
    assign out_blue  = st_q.comp[2];
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] sel_red,
    input logic [31:0] sel_green,
    input logic [31:0] sel_blue,
    input logic        in_valid,
    input logic [31:0] in_word,
    input logic        in_visible,
    input logic        in_underrun,
    input logic        out_valid,
    input logic [7:0]  out_red,
    input logic [7:0]  out_green,
    input logic [7:0]  out_blue
);
    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_red) && $stable(out_green) && $stable(out_blue)));

    assert_hidden_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_visible) |=>
        (out_red == $past(sel_red[23:16]) && out_green == $past(sel_green[23:16])
         && out_blue == $past(sel_blue[23:16])));

    assert_underrun_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_underrun) |=>
        (out_red == $past(sel_red[23:16]) && out_green == $past(sel_green[23:16])
         && out_blue == $past(sel_blue[23:16])));

    assert_len_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_green[11:8] == 4'd0) |=> out_green == $past(sel_green[23:16]));

    assert_first_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_visible && !in_underrun && sel_blue[11:8] == 4'd8
         && sel_blue[4:0] == 5'd0) |=> out_blue == $past(in_word[7:0]));
endmodule

bind pixel_unpacker pxu_checker u_pxu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_red     (sel_red),
    .sel_green   (sel_green),
    .sel_blue    (sel_blue),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .in_visible  (in_visible),
    .in_underrun (in_underrun),
    .out_valid   (out_valid),
    .out_red     (out_red),
    .out_green   (out_green),
    .out_blue    (out_blue)
);

// File: tb/pixel_unpacker_bench.sv
module pixel_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pixfmt_cfg, sel_red, sel_green, sel_blue, in_word;
    logic        in_valid, in_visible, in_underrun;
    logic        out_valid;
    logic [7:0]  out_red, out_green, out_blue;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    pixel_unpacker u_pixel_unpacker (
        .clk(clk), .rst_n(rst_n), .pixfmt_cfg(pixfmt_cfg),
        .sel_red(sel_red), .sel_green(sel_green), .sel_blue(sel_blue),
        .in_valid(in_valid), .in_word(in_word), .in_visible(in_visible),
        .in_underrun(in_underrun), .out_valid(out_valid),
        .out_red(out_red), .out_green(out_green), .out_blue(out_blue)
    );

    typedef struct packed {
        logic [31:0] fmt;
        logic [31:0] sr;
        logic [31:0] sg;
        logic [31:0] sb;
        logic [31:0] word;
        logic        vis;
        logic        und;
        logic [23:0] exp_rgb;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R6: two-byte pixel, upper bytes ignored; R7 for 5/6-bit fields
        '{32'h08, 32'h0000_050B, 32'h0000_0605, 32'h0000_0500, 32'hFFFF_F800, 1'b1, 1'b0, 24'hFF_00_00},
        '{32'h08, 32'h0000_050B, 32'h0000_0605, 32'h0000_0500, 32'h0000_07E0, 1'b1, 1'b0, 24'h00_FF_00},
        '{32'h08, 32'h0000_050B, 32'h0000_0605, 32'h0000_0500, 32'h0000_001F, 1'b1, 1'b0, 24'h00_00_FF},
        '{32'h08, 32'h0000_050B, 32'h0000_0605, 32'h0000_0500, 32'h0000_8410, 1'b1, 1'b0, 24'h84_82_84},
        // R2/R8: 8-bit fields, four bytes
        '{32'h18, 32'h0000_0810, 32'h0000_0808, 32'h0000_0800, 32'h0012_3456, 1'b1, 1'b0, 24'h12_34_56},
        // R6: three bytes, fourth byte reads zero
        '{32'h10, 32'h0000_0818, 32'h0000_0808, 32'h0000_0800, 32'hAB12_3456, 1'b1, 1'b0, 24'h00_34_56},
        // R8: 10-bit fields keep top 8 bits
        '{32'h18, 32'h0000_0A14, 32'h0000_0A0A, 32'h0000_0A00, 32'h3FC8_0D55, 1'b1, 1'b0, 24'hFF_80_55},
        // R3 green off, R7 3-bit and 2-bit fields, one byte
        '{32'h00, 32'h0000_0305, 32'h005A_0000, 32'h0000_0200, 32'hFFFF_FFA1, 1'b1, 1'b0, 24'hB6_5A_55},
        // R4: outside visible area
        '{32'h08, 32'h0011_050B, 32'h0022_0605, 32'h0033_0500, 32'h0000_FFFF, 1'b0, 1'b0, 24'h11_22_33},
        // R5: underrun
        '{32'h08, 32'h00FF_050B, 32'h0000_0605, 32'h0080_0500, 32'h0000_F800, 1'b1, 1'b1, 24'hFF_00_80},
        // R6: field runs past bit 31
        '{32'h18, 32'h0000_081C, 32'h0000_0000, 32'h0000_0000, 32'hF000_0000, 1'b1, 1'b0, 24'h0F_00_00}
    };

    task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        pixfmt_cfg  = v.fmt;
        sel_red     = v.sr;
        sel_green   = v.sg;
        sel_blue    = v.sb;
        in_word     = v.word;
        in_visible  = v.vis;
        in_underrun = v.und;
        in_valid    = vld;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(VECS[0], 1'b1);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {out_valid, out_red, out_green, out_blue}, 25'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], 1'b1);
            @(negedge clk);
            check($sformatf("R2 vector %0d", i), {out_valid, out_red, out_green, out_blue},
                  {1'b1, VECS[i].exp_rgb});
        end

        // R9: idle beat with different data leaves components unchanged
        drive(VECS[4], 1'b0);
        @(negedge clk);
        check("R9 hold", {out_valid, out_red, out_green, out_blue}, {1'b0, VECS[NV-1].exp_rgb});
        @(negedge clk);
        check("R9 hold second", {out_valid, out_red, out_green, out_blue}, {1'b0, VECS[NV-1].exp_rgb});

        // R1: single-cycle latency
        drive(VECS[4], 1'b1);
        @(negedge clk);
        check("R1 latency", {out_valid, out_red, out_green, out_blue}, {1'b1, 24'h12_34_56});

        // R5: underrun overrides even invisible beats, defaults from select words
        drive(VECS[9], 1'b1);
        in_visible = 1'b0;
        @(negedge clk);
        check("R5 underrun", {out_valid, out_red, out_green, out_blue}, {1'b1, 24'hFF_00_80});

        // R7: 1-bit field fills all eight bits
        drive(VECS[7], 1'b1);
        sel_red = 32'h0000_0107;
        in_word = 32'h0000_0080;
        @(negedge clk);
        check("R7 one bit", {out_valid, out_red}, {1'b1, 8'hFF});

        // R1: reset clears again mid-stream
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", {out_valid, out_red, out_green, out_blue}, 25'h0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule